// File: doc/BRIEF.md
# Delayed Dual-Stream Burst Strobe Generator

The block turns one system clock into two bursts of sample strobes, one meant to pace a digital-to-analog converter and one to pace an analog-to-digital converter. Both bursts run on a single shared sample grid whose period is set in system clocks. A start pulse loads the configuration and launches one measurement. The output-converter stream fires on the first grid slot. The input-converter stream waits a whole number of grid periods first. That wait can be hundreds of thousands of periods long, far longer than one sample period. Each stream then emits the same programmed number of single-cycle strobes.

After both streams have emitted their strobes the block goes idle and holds a done flag until the next start or an abort. Configuration inputs are captured only when a burst is accepted. Start pulses that arrive during a burst are ignored. An abort input clears everything on the next clock edge and does not raise done.

Top module: `burst_tick_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `busy`, `done`, `dac_tick` and `adc_tick` are all 0.
- R2: A start accepted at clock edge E0 makes `dac_tick` high for exactly one cycle after edges E(1 + j·P), for j = 0 … N−1. P is `cfg_period_m1` + 1 and N is `cfg_count`.
- R3: `adc_tick` is high for exactly one cycle after edges E(1 + j·P), for j = D … D+N−1, where D is `cfg_offset` in whole periods. With D = 0 the first strobes of the two streams coincide, and every input-converter strobe lies on the same grid as the output-converter strobes.
- R4: `busy` reads 1 from edge E0 until the edge that issues the last strobe of either stream, which is E(1 + (D+N−1)·P). At that edge `busy` falls and `done` rises.
- R5: `done` stays high while idle until the next accepted start or an abort. A new start clears it at edge E0.
- R6: When N = 0 no strobe is issued, and `done` rises at edge E1.
- R7: A start pulse seen while `busy` is 1 has no effect on strobes, `busy` or `done`.
- R8: Changes to `cfg_period_m1`, `cfg_count` and `cfg_offset` after E0 have no effect on the running burst.
- R9: An abort high at a clock edge forces `busy`, `done`, `dac_tick` and `adc_tick` to 0 after that edge. Abort takes priority over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period_m1 | input | DIV_W | Sample period in clocks, minus one |
| cfg_count | input | CNT_W | Strobes per stream per burst |
| cfg_offset | input | OFS_W | Input-converter start delay in whole periods |
| start | input | 1 | Launch request, acted on only when not busy |
| abort | input | 1 | Return to idle without done |
| dac_tick | output | 1 | Output-converter sample strobe |
| adc_tick | output | 1 | Input-converter sample strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Both streams finished, held while idle |

## Verification
A wrong phase count or a wrongly captured period moves a strobe off its grid slot. This shows as a mismatch on the first strobe after the fault, within one period. A delay counter that is loaded or decremented incorrectly shifts the first `adc_tick` by whole periods. A broken completion check makes `busy` and `done` change on the wrong edge around the final strobe. Every output is compared every cycle against a model driven only by P, N and D, so each of these faults is reported in the cycle where it first shows at the ports.

// File: rtl/burst_tick_pkg.sv
package burst_tick_pkg;

  typedef enum logic [1:0] {
    BT_IDLE = 2'd0,
    BT_RUN  = 2'd1,
    BT_FIN  = 2'd2
  } bt_state_e;

  localparam int BT_STREAMS = 2;
  localparam int BT_DAC_IDX = 0;
  localparam int BT_ADC_IDX = 1;

endpackage

// File: rtl/bt_period_timer.sv
module bt_period_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] period_m1_i,
  output logic             grid_o
);

  logic [DIV_W-1:0] period_q;
  logic [DIV_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      phase_q  <= '0;
    end else if (load) begin
      period_q <= period_m1_i;
      phase_q  <= '0;
    end else if (run) begin
      if (phase_q == period_q) phase_q <= '0;
      else                     phase_q <= phase_q + 1'b1;
    end
  end

  assign grid_o = run && (phase_q == '0);

  // R2: the phase never leaves the captured period range
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (phase_q <= period_q));

  // R8: the captured period holds still while running
  a_r8_period_held: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> (run -> $stable(period_q)));

endmodule

// File: rtl/bt_stream.sv
module bt_stream #(
  parameter int CNT_W = 16,
  parameter int OFS_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic             grid,
  input  logic [CNT_W-1:0] count_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic             tick_o,
  output logic             fin_o,
  output logic             last_o
);

  logic [OFS_W-1:0] wait_q;
  logic [CNT_W-1:0] remain_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wait_q   <= '0;
      remain_q <= '0;
      tick_q   <= 1'b0;
    end else if (load) begin
      wait_q   <= offset_i;
      remain_q <= count_i;
      tick_q   <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (grid) begin
        if (wait_q != '0) begin
          wait_q <= wait_q - 1'b1;
        end else if (remain_q != '0) begin
          remain_q <= remain_q - 1'b1;
          tick_q   <= 1'b1;
        end
      end
    end
  end

  assign tick_o = tick_q;
  assign fin_o  = (remain_q == '0);
  assign last_o = grid && (wait_q == '0) && (remain_q == CNT_W'(1));

  // R3: no strobe on a grid slot still inside the delay window
  a_r3_wait_blocks_tick: assert property (@(posedge clk) disable iff (rst)
    (grid && !clear && !load && (wait_q != '0)) |=> !tick_q);

  // R2: a strobe consumes exactly one unit of the remaining budget
  a_r2_budget_step: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (remain_q == $past(remain_q) - 1'b1));

endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import burst_tick_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic all_end,
  output logic load_o,
  output logic run_o,
  output logic busy_o,
  output logic done_o
);

  bt_state_e state_q;

  assign load_o = start && !abort && (state_q != BT_RUN);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state_q <= BT_IDLE;
    end else if (load_o) begin
      state_q <= BT_RUN;
    end else if (state_q == BT_RUN && all_end) begin
      state_q <= BT_FIN;
    end
  end

  assign run_o  = (state_q == BT_RUN);
  assign busy_o = (state_q == BT_RUN);
  assign done_o = (state_q == BT_FIN);

  // R5: done only arises from a running burst
  a_r5_done_from_run: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(state_q == BT_RUN));

  // R7: a running burst ignores start until it ends or is aborted
  a_r7_run_sticky: assert property (@(posedge clk) disable iff (rst)
    (run_o && !abort && !all_end) |=> run_o);

endmodule

// File: rtl/burst_tick_gen.sv
module burst_tick_gen
  import burst_tick_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16,
  parameter int OFS_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_period_m1,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic             start,
  input  logic             abort,
  output logic             dac_tick,
  output logic             adc_tick,
  output logic             busy,
  output logic             done
);

  logic                  load;
  logic                  run;
  logic                  grid;
  logic                  all_end;
  logic [BT_STREAMS-1:0] tick_v;
  logic [BT_STREAMS-1:0] fin_v;
  logic [BT_STREAMS-1:0] last_v;

  bt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .abort   (abort),
    .all_end (all_end),
    .load_o  (load),
    .run_o   (run),
    .busy_o  (busy),
    .done_o  (done)
  );

  bt_period_timer #(.DIV_W(DIV_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .run         (run),
    .period_m1_i (cfg_period_m1),
    .grid_o      (grid)
  );

  for (genvar s = 0; s < BT_STREAMS; s++) begin : g_stream
    logic [OFS_W-1:0] ofs_sel;
    if (s == BT_DAC_IDX) begin : g_lead
      assign ofs_sel = '0;
    end else begin : g_lag
      assign ofs_sel = cfg_offset;
    end
    bt_stream #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_stream (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .clear    (abort),
      .grid     (grid),
      .count_i  (cfg_count),
      .offset_i (ofs_sel),
      .tick_o   (tick_v[s]),
      .fin_o    (fin_v[s]),
      .last_o   (last_v[s])
    );
  end

  assign all_end  = &(fin_v | last_v);
  assign dac_tick = tick_v[BT_DAC_IDX];
  assign adc_tick = tick_v[BT_ADC_IDX];

  // R9: abort leaves every output low on the following cycle
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !done && !dac_tick && !adc_tick));

  // R4: busy and done never overlap
  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R2: strobes only follow a cycle spent running
  a_r2_tick_needs_busy: assert property (@(posedge clk) disable iff (rst)
    (dac_tick || adc_tick) |-> $past(busy));

  // R3: every strobe sits on a grid slot of the shared period
  a_r3_common_grid: assert property (@(posedge clk) disable iff (rst)
    (dac_tick || adc_tick) |-> $past(grid));

endmodule

// File: tb/burst_tick_gen_test.sv
`timescale 1ns/1ps
module burst_tick_gen_test;

  localparam int DIV_W = 16;
  localparam int CNT_W = 16;
  localparam int OFS_W = 18;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] cfg_period_m1 = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic [OFS_W-1:0] cfg_offset = '0;
  logic             start = 1'b0;
  logic             abort = 1'b0;
  logic             dac_tick, adc_tick, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_tick_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst(rst), .cfg_period_m1(cfg_period_m1), .cfg_count(cfg_count),
    .cfg_offset(cfg_offset), .start(start), .abort(abort),
    .dac_tick(dac_tick), .adc_tick(adc_tick), .busy(busy), .done(done)
  );

  function automatic bit exp_tick(int k, int pm1, int n, int first);
    int p = pm1 + 1;
    if (k < 1) return 1'b0;
    if (((k - 1) % p) != 0) return 1'b0;
    return ((k - 1) / p >= first) && ((k - 1) / p < first + n);
  endfunction

  function automatic int last_edge(int pm1, int n, int ofs);
    if (n == 0) return 1;
    return 1 + (ofs + n - 1) * (pm1 + 1);
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_burst(int pm1, int n, int ofs, bit disturb);
    int last = last_edge(pm1, n, ofs);
    @(negedge clk);
    cfg_period_m1 = DIV_W'(pm1);
    cfg_count     = CNT_W'(n);
    cfg_offset    = OFS_W'(ofs);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= last + 2; k++) begin
      check(dac_tick, exp_tick(k, pm1, n, 0), "R2", "dac_tick");
      check(adc_tick, exp_tick(k, pm1, n, ofs), "R3", "adc_tick");
      check(busy, k < last, "R4", "busy");
      check(done, k >= last, (n == 0) ? "R6" : "R5", "done");
      if (disturb && k < last && (k % 3) == 1) begin
        // R7 / R8: restart attempt and config scramble mid-burst
        cfg_period_m1 = DIV_W'($urandom_range(0, 7));
        cfg_count     = CNT_W'($urandom_range(0, 9));
        cfg_offset    = OFS_W'($urandom_range(0, 9));
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic abort_burst(int pm1, int n, int ofs, int after);
    @(negedge clk);
    cfg_period_m1 = DIV_W'(pm1);
    cfg_count     = CNT_W'(n);
    cfg_offset    = OFS_W'(ofs);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (after) @(negedge clk);
    abort = 1'b1;
    start = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(busy, 1'b0, "R9", "busy");
      check(done, 1'b0, "R9", "done");
      check(dac_tick, 1'b0, "R9", "dac_tick");
      check(adc_tick, 1'b0, "R9", "adc_tick");
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(busy, 1'b0, "R1", "busy in reset");
    check(done, 1'b0, "R1", "done in reset");
    check(dac_tick | adc_tick, 1'b0, "R1", "ticks in reset");
    rst = 1'b0;
    @(negedge clk);
    check(busy | done | dac_tick | adc_tick, 1'b0, "R1", "outputs after reset");

    // directed corners
    run_burst(0, 3, 0, 1'b0);   // R3 offset 0, period 1
    run_burst(3, 4, 0, 1'b0);   // R3 coincident starts
    run_burst(2, 2, 5, 1'b0);   // R3 offset beyond dac end
    run_burst(4, 6, 2, 1'b0);   // R4 overlap of streams
    run_burst(1, 0, 3, 1'b0);   // R6 empty burst
    run_burst(2, 5, 3, 1'b1);   // R7 R8 disturbance
    run_burst(0, 4, 20000, 1'b0); // R3 long delay
    abort_burst(2, 5, 4, 6);    // R9 abort mid-burst
    run_burst(1, 3, 1, 1'b0);   // recovery after abort
    abort_burst(0, 2, 0, 0);    // R9 abort right after start

    for (int t = 0; t < 30; t++) begin
      run_burst($urandom_range(0, 5), $urandom_range(0, 8),
                $urandom_range(0, 12), 1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule